// File: doc/BRIEF.md
# Legacy Memory Region Attribute Router

This block sits on the CPU memory path and steers every access that lands in the upper legacy window, 0xC0000 through 0xFFFFF, either to system DRAM or to the ROM/bus side. Each 16 KB or 64 KB piece of that window has its own read-enable and write-enable attribute. Reads and writes can therefore be routed apart. Firmware uses this to copy ROM images into DRAM: it reads the ROM while writing DRAM, then switches reads over to DRAM.

The attributes live in seven byte registers that a configuration port reaches at offsets 0x59 to 0x5F. Each byte holds two 4-bit fields, and a per-nibble write enable lets software change one field without touching the other. Routing is combinational on the CPU request. A new attribute value acts from the clock edge that captures the configuration write.

Top module: `legacy_shadow_router`

## Requirements
- R1: After reset, all seven attribute bytes at offsets 0x59..0x5F read 0x00, so every access in the window goes to the ROM/bus side.
- R2: A configuration write at offsets 0x59..0x5F updates bits [3:0] when cfg_we[0] is 1 and bits [7:4] when cfg_we[1] is 1, and leaves the other nibble unchanged. Configuration reads at those offsets return the stored byte. Any other offset reads 0x00 and ignores writes.
- R3: Segment n uses attribute byte 0x59 + n/2. Even n uses bits [3:0] and odd n uses bits [7:4]. Segment 1 is 0xF0000–0xFFFFF. Segments 2..9 are the 16 KB blocks from 0xC0000, in ascending order. Segments 10..13 are the 16 KB blocks from 0xE0000. Segment 0 maps no address.
- R4: Within a field, bit 0 is read-enable. A read in a segment with bit 0 set goes to DRAM and returns DRAM data. With bit 0 clear, the read goes to the ROM/bus port and returns its data.
- R5: Within a field, bit 1 is write-enable. A write in a segment with bit 1 set goes to DRAM. With bit 1 clear, the write goes to the ROM/bus port and DRAM is not written.
- R6: Accesses below 0xC0000 always go to DRAM, whatever the attributes hold.
- R7: During a CPU request, exactly one of dram_req and rom_req is high. The write strobe is passed to that port only, and cpu_rdata comes from that port. With no request, neither port is requested.
- R8: A configuration write does not affect a CPU access in the same cycle. It governs accesses from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_addr | input | 8 | Configuration byte offset |
| cfg_wdata | input | 8 | Configuration write byte |
| cfg_we | input | 2 | Per-nibble configuration write enable (bit 0 low nibble, bit 1 high nibble) |
| cfg_rdata | output | 8 | Configuration read byte |
| cpu_req | input | 1 | CPU access valid |
| cpu_we | input | 1 | CPU access is a write |
| cpu_addr | input | 20 | CPU byte address |
| cpu_wdata | input | 8 | CPU write byte |
| cpu_rdata | output | 8 | CPU read byte from the selected port |
| dram_req | output | 1 | DRAM access strobe |
| dram_we | output | 1 | DRAM write strobe |
| dram_addr | output | 20 | DRAM address |
| dram_wdata | output | 8 | DRAM write byte |
| dram_rdata | input | 8 | DRAM read byte |
| rom_req | output | 1 | ROM/bus access strobe |
| rom_we | output | 1 | ROM/bus write strobe |
| rom_addr | output | 20 | ROM/bus address |
| rom_wdata | output | 8 | ROM/bus write byte |
| rom_rdata | input | 8 | ROM/bus read byte |

## Verification
Port selection, the write strobes and cpu_rdata are combinational from the CPU request. They are due in the same cycle the request is driven, so the monitor samples a quarter period after the falling edge on which the driver applied it. A DRAM write commits at the next rising edge and is checked by a later read. A configuration write takes effect at the rising edge that follows it. The bench checks the old routing in the write cycle itself and the new routing one cycle later. Configuration reads are combinational and are sampled in the same cycle.

// File: rtl/legacy_shadow_router.sv
module legacy_shadow_router #(
  parameter int ADDR_W   = 20,
  parameter int DATA_W   = 8,
  parameter int CFG_AW   = 8,
  parameter int CFG_BASE = 'h59,
  parameter int NUM_REGS = 7
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [CFG_AW-1:0] cfg_addr,
  input  logic [7:0]        cfg_wdata,
  input  logic [1:0]        cfg_we,
  output logic [7:0]        cfg_rdata,
  input  logic              cpu_req,
  input  logic              cpu_we,
  input  logic [ADDR_W-1:0] cpu_addr,
  input  logic [DATA_W-1:0] cpu_wdata,
  output logic [DATA_W-1:0] cpu_rdata,
  output logic              dram_req,
  output logic              dram_we,
  output logic [ADDR_W-1:0] dram_addr,
  output logic [DATA_W-1:0] dram_wdata,
  input  logic [DATA_W-1:0] dram_rdata,
  output logic              rom_req,
  output logic              rom_we,
  output logic [ADDR_W-1:0] rom_addr,
  output logic [DATA_W-1:0] rom_wdata,
  input  logic [DATA_W-1:0] rom_rdata
);

  localparam logic [ADDR_W-1:0] WIN_C = ADDR_W'('hC0000);
  localparam logic [ADDR_W-1:0] WIN_E = ADDR_W'('hE0000);
  localparam logic [ADDR_W-1:0] WIN_F = ADDR_W'('hF0000);
  localparam logic [ADDR_W-1:0] WIN_X = ADDR_W'('hFFFFF);

  logic [NUM_REGS-1:0][7:0] attr_q;
  logic [CFG_AW-1:0]        cfg_off;
  logic                     cfg_hit;
  logic [3:0]               seg;
  logic                     win_hit;
  logic [3:0]               fld;
  logic                     to_dram;

  assign cfg_off = cfg_addr - CFG_AW'(CFG_BASE);
  assign cfg_hit = (cfg_addr >= CFG_AW'(CFG_BASE)) &&
                   (cfg_addr <  CFG_AW'(CFG_BASE + NUM_REGS));

  for (genvar i = 0; i < NUM_REGS; i++) begin : g_attr
    always_ff @(posedge clk) begin
      if (!rst_n) begin
        attr_q[i] <= 8'h00;
      end else if (cfg_hit && cfg_off == CFG_AW'(i)) begin
        if (cfg_we[0]) attr_q[i][3:0] <= cfg_wdata[3:0];
        if (cfg_we[1]) attr_q[i][7:4] <= cfg_wdata[7:4];
      end
    end
  end

  always_comb begin
    cfg_rdata = 8'h00;
    for (int i = 0; i < NUM_REGS; i++)
      if (cfg_hit && cfg_off == CFG_AW'(i)) cfg_rdata = attr_q[i];
  end

  always_comb begin
    win_hit = 1'b1;
    seg     = 4'd0;
    if (cpu_addr >= WIN_F && cpu_addr <= WIN_X)
      seg = 4'd1;
    else if (cpu_addr >= WIN_E && cpu_addr < WIN_F)
      seg = 4'd10 + {2'b00, cpu_addr[15:14]};
    else if (cpu_addr >= WIN_C && cpu_addr < WIN_E)
      seg = 4'd2 + {1'b0, cpu_addr[16:14]};
    else
      win_hit = 1'b0;
  end

  always_comb begin
    fld = 4'h0;
    for (int i = 0; i < NUM_REGS; i++)
      if (seg[3:1] == 3'(i)) fld = seg[0] ? attr_q[i][7:4] : attr_q[i][3:0];
  end

  assign to_dram    = !win_hit || (cpu_we ? fld[1] : fld[0]);

  assign dram_req   = cpu_req && to_dram;
  assign rom_req    = cpu_req && !to_dram;
  assign dram_we    = dram_req && cpu_we;
  assign rom_we     = rom_req && cpu_we;
  assign dram_addr  = cpu_addr;
  assign rom_addr   = cpu_addr;
  assign dram_wdata = cpu_wdata;
  assign rom_wdata  = cpu_wdata;
  assign cpu_rdata  = to_dram ? dram_rdata : rom_rdata;

  AST_ONE_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req |-> $countones({dram_req, rom_req}) == 1); // R7
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_req |-> !dram_req && !rom_req && !dram_we && !rom_we); // R7
  AST_ROM_RDATA: assert property (@(posedge clk) disable iff (!rst_n)
    rom_req && !cpu_we |-> cpu_rdata == rom_rdata); // R7
  AST_LOW_TO_DRAM: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_req && cpu_addr < WIN_C |-> dram_req); // R6
  AST_ATTR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_we == 2'b00 |=> $stable(attr_q)); // R2
  AST_FOREIGN_CFG: assert property (@(posedge clk) disable iff (!rst_n)
    !cfg_hit |=> $stable(attr_q)); // R2

endmodule

// File: tb/legacy_shadow_router_tb.sv
module legacy_shadow_router_tb;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  cfg_addr = '0, cfg_wdata = '0, cfg_rdata;
  logic [1:0]  cfg_we = '0;
  logic        cpu_req = 1'b0, cpu_we = 1'b0;
  logic [19:0] cpu_addr = '0;
  logic [7:0]  cpu_wdata = '0, cpu_rdata;
  logic        dram_req, dram_we, rom_req, rom_we;
  logic [19:0] dram_addr, rom_addr;
  logic [7:0]  dram_wdata, rom_wdata, dram_rdata, rom_rdata;

  always #(CLK_P/2) clk = ~clk;

  legacy_shadow_router u_dut (
    .clk(clk), .rst_n(rst_n),
    .cfg_addr(cfg_addr), .cfg_wdata(cfg_wdata), .cfg_we(cfg_we), .cfg_rdata(cfg_rdata),
    .cpu_req(cpu_req), .cpu_we(cpu_we), .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata),
    .cpu_rdata(cpu_rdata),
    .dram_req(dram_req), .dram_we(dram_we), .dram_addr(dram_addr),
    .dram_wdata(dram_wdata), .dram_rdata(dram_rdata),
    .rom_req(rom_req), .rom_we(rom_we), .rom_addr(rom_addr),
    .rom_wdata(rom_wdata), .rom_rdata(rom_rdata)
  );

  // Behavioural stand-ins for DRAM and ROM
  logic [7:0] dmem [int];
  int         wr_cnt = 0;

  function automatic logic [7:0] dmem_rd(input logic [19:0] a, input int tick);
    int unused;
    unused = tick;
    return dmem.exists(int'(a)) ? dmem[int'(a)] : 8'h00;
  endfunction

  function automatic logic [7:0] romv(input logic [19:0] a);
    return a[7:0] ^ a[15:8] ^ 8'h3C;
  endfunction

  assign dram_rdata = dmem_rd(dram_addr, wr_cnt);
  assign rom_rdata  = romv(rom_addr);

  always @(posedge clk) begin
    if (dram_req && dram_we) begin
      dmem[int'(dram_addr)] = dram_wdata;
      wr_cnt = wr_cnt + 1;
    end
  end

  // Reference model
  logic [7:0] battr [7];
  logic [7:0] bdram [int];

  function automatic int bseg(input logic [19:0] a);
    int ai;
    ai = int'(a);
    if (ai >= 'hF0000) return 1;
    if (ai >= 'hE0000) return 10 + (ai - 'hE0000) / 'h4000;
    if (ai >= 'hC0000) return 2 + (ai - 'hC0000) / 'h4000;
    return -1;
  endfunction

  function automatic bit exp_dram(input logic [19:0] a, input bit w);
    int s;
    logic [7:0] b;
    logic [3:0] f;
    s = bseg(a);
    if (s < 0) return 1'b1;
    b = battr[s / 2];
    f = (s % 2 == 1) ? b[7:4] : b[3:0];
    return w ? f[1] : f[0];
  endfunction

  typedef struct {
    bit         is_cfg;
    bit         is_wr;
    bit         to_dram;
    logic [7:0] data;
    string      tag;
  } item_t;

  item_t q[$];
  int    n_checks = 0;
  int    n_fail = 0;
  bit    done = 1'b0;

  // Monitor: compare a quarter period after each falling edge
  initial begin
    forever begin
      @(negedge clk);
      #(CLK_P/4);
      while (q.size() > 0) begin
        item_t it;
        it = q.pop_front();
        n_checks++;
        if (it.is_cfg) begin
          if (cfg_rdata !== it.data) begin
            n_fail++;
            $display("FAIL %s cfg_rdata act=%02h exp=%02h", it.tag, cfg_rdata, it.data);
          end
        end else if (dram_req !== it.to_dram || rom_req !== !it.to_dram) begin
          n_fail++;
          $display("FAIL %s route act dram=%b rom=%b exp dram=%b", it.tag,
                   dram_req, rom_req, it.to_dram);
        end else if (it.is_wr && (it.to_dram ? (dram_we !== 1'b1 || rom_we !== 1'b0)
                                             : (rom_we !== 1'b1 || dram_we !== 1'b0))) begin
          n_fail++;
          $display("FAIL %s write strobes act dram_we=%b rom_we=%b exp dram=%b", it.tag,
                   dram_we, rom_we, it.to_dram);
        end else if (!it.is_wr && cpu_rdata !== it.data) begin
          n_fail++;
          $display("FAIL %s cpu_rdata act=%02h exp=%02h", it.tag, cpu_rdata, it.data);
        end
      end
    end
  end

  task automatic push_cpu(input bit w, input logic [19:0] a, input logic [7:0] d,
                          input string tag);
    item_t it;
    it.is_cfg  = 1'b0;
    it.is_wr   = w;
    it.to_dram = exp_dram(a, w);
    it.tag     = tag;
    if (w) begin
      it.data = d;
      if (it.to_dram) bdram[int'(a)] = d;
    end else begin
      it.data = it.to_dram ? (bdram.exists(int'(a)) ? bdram[int'(a)] : 8'h00) : romv(a);
    end
    q.push_back(it);
  endtask

  task automatic cpu_op(input bit w, input logic [19:0] a, input logic [7:0] d,
                        input string tag);
    @(negedge clk);
    cfg_we = 2'b00; cpu_req = 1'b1; cpu_we = w; cpu_addr = a; cpu_wdata = d;
    push_cpu(w, a, d, tag);
  endtask

  task automatic cfg_wr(input logic [7:0] off, input logic [7:0] d, input logic [1:0] nib);
    @(negedge clk);
    cpu_req = 1'b0; cfg_addr = off; cfg_wdata = d; cfg_we = nib;
    if (off >= 8'h59 && off <= 8'h5F) begin
      if (nib[0]) battr[off - 8'h59][3:0] = d[3:0];
      if (nib[1]) battr[off - 8'h59][7:4] = d[7:4];
    end
  endtask

  task automatic cfg_rd(input logic [7:0] off, input string tag);
    item_t it;
    @(negedge clk);
    cpu_req = 1'b0; cfg_we = 2'b00; cfg_addr = off;
    it.is_cfg = 1'b1; it.is_wr = 1'b0; it.to_dram = 1'b0; it.tag = tag;
    it.data = (off >= 8'h59 && off <= 8'h5F) ? battr[off - 8'h59] : 8'h00;
    q.push_back(it);
  endtask

  task automatic set_seg(input int s, input logic [3:0] f);
    cfg_wr(8'(8'h59 + s / 2), {f, f}, (s % 2 == 1) ? 2'b10 : 2'b01);
  endtask

  task automatic idle();
    @(negedge clk);
    cpu_req = 1'b0; cfg_we = 2'b00;
  endtask

  initial begin
    #(CLK_P * 100000);
    n_checks++;
    n_fail++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    for (int i = 0; i < 7; i++) battr[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset values of all attribute bytes
    for (int i = 0; i < 7; i++) cfg_rd(8'(8'h59 + i), "R1 reset attr");
    cpu_op(1'b0, 20'hF1234, 8'h00, "R1 reset routes window read to ROM");

    // R2: offsets outside the bank
    cfg_wr(8'h58, 8'hFF, 2'b11);
    cfg_rd(8'h58, "R2 foreign offset reads zero");
    cfg_rd(8'h60, "R2 offset past bank reads zero");
    for (int i = 0; i < 7; i++) cfg_rd(8'(8'h59 + i), "R2 foreign write ignored");

    // R2: nibble enables preserve the other half
    cfg_wr(8'h5A, 8'hA3, 2'b01);
    cfg_rd(8'h5A, "R2 low nibble write");
    cfg_wr(8'h5A, 8'h5C, 2'b10);
    cfg_rd(8'h5A, "R2 high nibble write keeps low");
    cfg_wr(8'h5A, 8'h00, 2'b11);
    cfg_rd(8'h5A, "R2 full byte clear");

    // R6: below the window always DRAM
    cfg_wr(8'h59, 8'h00, 2'b11);
    cpu_op(1'b1, 20'h00100, 8'h5A, "R6 low write to DRAM");
    cpu_op(1'b0, 20'h00100, 8'h00, "R6 low read from DRAM");
    cpu_op(1'b1, 20'hBFFFF, 8'h6B, "R6 edge write to DRAM");
    cpu_op(1'b0, 20'hBFFFF, 8'h00, "R6 edge read from DRAM");

    // R3, R4, R5: per-segment shadowing sequence
    for (int s = 1; s < 14; s++) begin
      int lo;
      int sz;
      lo = (s == 1) ? 'hF0000 : (s <= 9) ? 'hC0000 + (s - 2) * 'h4000
                                           : 'hE0000 + (s - 10) * 'h4000;
      sz = (s == 1) ? 'h10000 : 'h4000;
      set_seg(s, 4'h1);
      cpu_op(1'b0, 20'(lo), 8'h00, "R4 read-enable gives DRAM zero");
      cpu_op(1'b0, 20'(lo + sz - 1), 8'h00, "R3 segment end read-enable");
      set_seg(s, 4'h3);
      cpu_op(1'b1, 20'(lo), 8'h42, "R5 write-enable writes DRAM");
      cpu_op(1'b1, 20'(lo + sz - 1), 8'h42, "R3 segment end write");
      cpu_op(1'b0, 20'(lo), 8'h00, "R4 readback 0x42");
      cpu_op(1'b0, 20'(lo + sz - 1), 8'h00, "R3 segment end readback");
      if (s >= 2 && s != 9 && s != 13)
        cpu_op(1'b0, 20'(lo + sz), 8'h00, "R3 next segment unaffected");
      set_seg(s, 4'h2);
      cpu_op(1'b0, 20'(lo), 8'h00, "R5 write-only reads ROM");
      cpu_op(1'b1, 20'(lo), 8'h82, "R5 write-only writes DRAM");
      cpu_op(1'b0, 20'(lo), 8'h00, "R5 new data hidden behind ROM");
      set_seg(s, 4'h3);
      cpu_op(1'b0, 20'(lo), 8'h00, "R4 readback 0x82");
      set_seg(s, 4'h0);
      cpu_op(1'b0, 20'(lo), 8'h00, "R4 cleared field reads ROM");
      cpu_op(1'b1, 20'(lo), 8'h11, "R5 write with enable clear goes to ROM");
      set_seg(s, 4'h1);
      cpu_op(1'b0, 20'(lo), 8'h00, "R5 DRAM untouched by ROM write");
      set_seg(s, 4'h0);
      cfg_rd(8'(8'h59 + s / 2), "R2 attr after segment sequence");
    end

    // R8: write cycle uses the old attribute, next cycle the new one
    @(negedge clk);
    cfg_addr = 8'h5B; cfg_wdata = 8'h01; cfg_we = 2'b01;
    cpu_req = 1'b1; cpu_we = 1'b0; cpu_addr = 20'hC8010;
    push_cpu(1'b0, 20'hC8010, 8'h00, "R8 same cycle keeps old routing");
    battr[2][3:0] = 4'h1;
    cpu_op(1'b0, 20'hC8010, 8'h00, "R8 next cycle uses new routing");

    // R7: idle cycle requests nothing
    idle();
    #(CLK_P/4);
    n_checks++;
    if (dram_req !== 1'b0 || rom_req !== 1'b0) begin
      n_fail++;
      $display("FAIL R7 idle act dram=%b rom=%b exp 0 0", dram_req, rom_req);
    end
    idle();
    idle();
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule